// File: doc/BRIEF.md
# Banked GPIO Port Register File

This block is the register core of a general-purpose I/O controller. It splits a configurable number of pins into banks of eight lines. Each bank has two byte-wide registers. The data register latches the values the block drives. The direction register chooses, bit by bit, whether a line is an input or an output. Software reaches these registers over a 32-bit bus that uses byte addresses, one read strobe and one write strobe. Each write replaces the low byte of one register. Because of this, software sets single bits by read-modify-write of the whole byte.

Banks sit at a fixed stride of eight bytes, starting at 0x08. The address window 0x90 through 0x9F belongs to a separate interrupt-control block. No bank register is placed there, and every bank that would start at or above 0x90 is moved up by 0x10. Before a read can see an input pin, the pin passes through a two-flop synchronizer. A data read returns the synchronized pin for input lines and the latched value for output lines. The pin output values and output enables come straight from flops.

Top module: `gpio_bank_regfile`

## Requirements
- R1: There are ceil(NUM_PINS/8) banks, with pin n in bank n/8 at bit n%8. Bits at or above the pin count in the last bank read as 0, and writes to them are ignored.
- R2: Bank b has its register base at (b+1)*8. When that value is 0x90 or more, 0x10 is added to it. With the default 150 pins, bank 16 is at 0x88, bank 17 at 0xA0 and bank 18 at 0xA8.
- R3: The data register is at base+0 and the direction register is at base+4. Only word-aligned addresses (addr[1:0]=0) select a register.
- R4: A direction bit of 1 makes its line an input, so pin_oe is 0. A direction bit of 0 makes it an output: pin_oe is 1 and pin_out equals the data bit. pin_out always shows the latched data bit.
- R5: A write replaces bits [7:0] of one register in one bank and leaves every other register unchanged. wdata[31:8] is ignored, and reads return 0 in rdata[31:8].
- R6: A data-register read returns, for each bit, the latched data value if the line is an output, or the synchronized pin level if it is an input.
- R7: After reset every direction bit is 1 and every data bit is 0, so pin_oe and pin_out are all 0 and rdata is 0.
- R8: Any address that maps no register returns 0 on a read, and a write to it changes nothing. This includes the hole 0x90–0x9F, misaligned addresses and addresses past the last bank.
- R9: A read whose strobe is sampled at the first or second rising edge after a pin changes returns the old level. A read sampled at the third edge returns the new level.
- R10: rdata is registered and holds the result of a read sampled at the previous edge. In a cycle after an edge without a read, rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data, only bits [7:0] are used |
| rdata | output | 32 | Registered read data |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_out | output | NUM_PINS | Latched output values |
| pin_oe | output | NUM_PINS | Output enables, 1 = line driven |

## Verification
A wrong base calculation or a decode error next to the hole shows up as a register that appears at a second address, at the wrong address, or at no address. The next read sweep over every byte address exposes it, one cycle after the strobe. A corrupted direction or data flop appears on pin_oe or pin_out one cycle after the write that caused it. A synchronizer with the wrong depth moves the edge at which a read first sees a new pin level, so reads at the second and third edges after the change tell the difference.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int LINES_PER_BANK = 8;
  localparam int BANK_STRIDE    = 8;
  localparam int DIR_OFFSET     = 4;
  localparam int HOLE_LO        = 'h90;
  localparam int HOLE_SPAN      = 'h10;

  typedef enum logic [0:0] {
    REG_DATA = 1'b0,
    REG_DIR  = 1'b1
  } gpio_reg_e;

  // register base of a bank, skipping the interrupt window
  function automatic int bank_base(input int bank);
    int raw;
    raw = (bank + 1) * BANK_STRIDE;
    if (raw >= HOLE_LO) raw = raw + HOLE_SPAN;
    return raw;
  endfunction

  function automatic int bank_count(input int pins);
    return (pins + LINES_PER_BANK - 1) / LINES_PER_BANK;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= '0;
          else     stage_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int ADDR_W    = 8
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_BANKS-1:0] sel_data,
  output logic [NUM_BANKS-1:0] sel_dir
);

  genvar b;
  generate
    for (b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam int BASE_I = bank_base(b);
      localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(BASE_I);
      localparam logic [ADDR_W-1:0] DIR_A  = ADDR_W'(BASE_I + DIR_OFFSET);
      assign sel_data[b] = (addr == DATA_A);
      assign sel_dir[b]  = (addr == DIR_A);
    end
  endgenerate

endmodule

// File: rtl/gpio_bank_slice.sv
module gpio_bank_slice #(
  parameter int WIDTH  = 8,
  parameter int BANK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_data,
  input  logic              wr_dir,
  input  logic [BANK_W-1:0] wbyte,
  input  logic [WIDTH-1:0]  pin_sync,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe,
  output logic [BANK_W-1:0] rd_data,
  output logic [BANK_W-1:0] rd_dir
);

  logic [WIDTH-1:0] data_q;
  logic [WIDTH-1:0] oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      oe_q   <= '0;
    end else begin
      if (wr_data) data_q <= wbyte[WIDTH-1:0];
      if (wr_dir)  oe_q   <= ~wbyte[WIDTH-1:0];
    end
  end

  assign pin_out = data_q;
  assign pin_oe  = oe_q;

  always_comb begin
    rd_data = '0;
    rd_dir  = '0;
    rd_data[WIDTH-1:0] = (oe_q & data_q) | (~oe_q & pin_sync);
    rd_dir[WIDTH-1:0]  = ~oe_q;
  end

endmodule

// File: rtl/gpio_bank_regfile.sv
module gpio_bank_regfile
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS    = 150,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [31:0]         wdata,
  output logic [31:0]         rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);

  localparam int NUM_BANKS = bank_count(NUM_PINS);
  localparam int LAST_W    = NUM_PINS - LINES_PER_BANK * (NUM_BANKS - 1);

  logic [NUM_PINS-1:0]       pin_sync;
  logic [NUM_BANKS-1:0]      sel_data;
  logic [NUM_BANKS-1:0]      sel_dir;
  logic [LINES_PER_BANK-1:0] bank_rd_data [NUM_BANKS];
  logic [LINES_PER_BANK-1:0] bank_rd_dir  [NUM_BANKS];
  logic [LINES_PER_BANK-1:0] rd_val;
  logic                      unused_wdata_hi;

  assign unused_wdata_hi = ^wdata[31:LINES_PER_BANK];

  gpio_in_sync #(
    .WIDTH  (NUM_PINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pin_in),
    .sync_out (pin_sync)
  );

  gpio_addr_decode #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W)
  ) u_dec (
    .addr     (addr),
    .sel_data (sel_data),
    .sel_dir  (sel_dir)
  );

  genvar b;
  generate
    for (b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam int W  = (b == NUM_BANKS - 1) ? LAST_W : LINES_PER_BANK;
      localparam int LO = b * LINES_PER_BANK;
      gpio_bank_slice #(
        .WIDTH  (W),
        .BANK_W (LINES_PER_BANK)
      ) u_slice (
        .clk      (clk),
        .rst      (rst),
        .wr_data  (wr_en & sel_data[b]),
        .wr_dir   (wr_en & sel_dir[b]),
        .wbyte    (wdata[LINES_PER_BANK-1:0]),
        .pin_sync (pin_sync[LO +: W]),
        .pin_out  (pin_out[LO +: W]),
        .pin_oe   (pin_oe[LO +: W]),
        .rd_data  (bank_rd_data[b]),
        .rd_dir   (bank_rd_dir[b])
      );
    end
  endgenerate

  // one-hot selects: an OR of masked bank views forms the read mux
  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (sel_data[i]) rd_val = rd_val | bank_rd_data[i];
      if (sel_dir[i])  rd_val = rd_val | bank_rd_dir[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= {{(32-LINES_PER_BANK){1'b0}}, rd_val};
    else            rdata <= '0;
  end

endmodule

// File: rtl/gpio_bank_regfile_chk.sv
module gpio_bank_regfile_chk
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 150,
  parameter int ADDR_W   = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic                rd_en,
  input logic [ADDR_W-1:0]   addr,
  input logic [31:0]         rdata,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe
);

  localparam int NB = bank_count(NUM_PINS);

  logic was_rst = 1'b0;
  logic mapped;

  always_ff @(posedge clk) was_rst <= rst;

  always_comb begin
    mapped = 1'b0;
    for (int i = 0; i < NB; i++) begin
      if (int'(addr) == bank_base(i) || int'(addr) == bank_base(i) + DIR_OFFSET)
        mapped = 1'b1;
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    was_rst |-> (pin_oe == '0 && pin_out == '0 && rdata == '0)); // R7

  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en) |-> rdata == '0); // R10

  AST_RDATA_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
    rdata[31:8] == '0); // R5

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en && !mapped) |-> rdata == '0); // R8

  AST_UNMAPPED_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && !mapped) |-> ($stable(pin_out) && $stable(pin_oe))); // R8

  AST_NO_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> ($stable(pin_out) && $stable(pin_oe))); // R5

endmodule

bind gpio_bank_regfile gpio_bank_regfile_chk #(
  .NUM_PINS (NUM_PINS),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .addr    (addr),
  .rdata   (rdata),
  .pin_out (pin_out),
  .pin_oe  (pin_oe)
);

// File: tb/tb_gpio_bank_regfile.sv
`timescale 1ns/1ps
module tb_gpio_bank_regfile;

  localparam int NP = 150;
  localparam int AW = 8;
  localparam int NB = (NP + 7) / 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out;
  logic [NP-1:0] pin_oe;

  logic [NP-1:0] m_data = '0;
  logic [NP-1:0] m_dir  = '1;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  gpio_bank_regfile #(.NUM_PINS(NP), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe)
  );

  function automatic int bw(input int b);
    return (b == NB - 1) ? NP - 8 * (NB - 1) : 8;
  endfunction

  function automatic int bbase(input int b);
    int r;
    r = 8 * b + 8;
    return (r < 144) ? r : r + 16;
  endfunction

  function automatic logic [31:0] exp_read(input int a);
    logic [31:0] v;
    v = '0;
    for (int b = 0; b < NB; b++) begin
      for (int i = 0; i < bw(b); i++) begin
        if (a == bbase(b))
          v[i] = m_dir[8*b+i] ? pin_in[8*b+i] : m_data[8*b+i];
        if (a == bbase(b) + 4)
          v[i] = m_dir[8*b+i];
      end
    end
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [NP-1:0] act,
                       input logic [NP-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input int a, input logic [31:0] w);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = w;
    @(negedge clk);
    wr_en = 1'b0;
    for (int b = 0; b < NB; b++) begin
      for (int i = 0; i < bw(b); i++) begin
        if (a == bbase(b))     m_data[8*b+i] = w[i];
        if (a == bbase(b) + 4) m_dir[8*b+i]  = w[i];
      end
    end
  endtask

  task automatic do_read(input int a, output logic [31:0] r);
    @(negedge clk);
    rd_en = 1'b1; addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
    r = rdata;
  endtask

  // R1 R2 R3 R6 R8: every byte address against the model
  task automatic sweep(input string tag);
    logic [31:0] r;
    for (int a = 0; a < 256; a++) begin
      do_read(a, r);
      check(r == exp_read(a), tag, NP'(r), NP'(exp_read(a)));
    end
  endtask

  task automatic check_pins(input string tag);
    check(pin_out == m_data, {tag, " pin_out"}, pin_out, m_data);
    check(pin_oe == ~m_dir, {tag, " pin_oe"}, pin_oe, ~m_dir);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [NP-1:0] keep_oe;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7 reset state
    check(pin_oe == '0, "R7 reset pin_oe", pin_oe, '0);
    check(pin_out == '0, "R7 reset pin_out", pin_out, '0);
    check(rdata == '0, "R7 reset rdata", NP'(rdata), '0);
    sweep("R7 R2 R3 R1 reset sweep");

    // R4 R5 R6: distinct patterns per bank, mixed pins
    for (int p = 0; p < NP; p++) pin_in[p] = ((p * 7 + 3) % 5) < 2;
    for (int b = 0; b < NB; b++) begin
      do_write(bbase(b), 32'(((b * 37) + 5) & 255) | 32'hA5A5_0000);
      do_write(bbase(b) + 4, 32'(((b * 91) + 170) & 255));
    end
    repeat (4) @(negedge clk);
    check_pins("R4");
    sweep("R6 R5 R1 pattern sweep");

    // R5 upper write bits ignored
    do_write(bbase(2) + 4, 32'h0);
    do_write(bbase(2), 32'hABCD_EF5A);
    do_read(bbase(2), r);
    check(r == 32'h5A, "R5 upper wdata ignored", NP'(r), NP'(32'h5A));

    // R5 read-modify-write one bit
    keep_oe = pin_oe;
    do_read(bbase(3) + 4, r);
    do_write(bbase(3) + 4, r ^ 32'h20);
    keep_oe[3*8+5] = ~keep_oe[3*8+5];
    check(pin_oe == keep_oe, "R5 single-bit rmw", pin_oe, keep_oe);

    // R1 partial last bank
    do_write(bbase(NB - 1), 32'hFF);
    do_write(bbase(NB - 1) + 4, 32'h00);
    do_read(bbase(NB - 1) + 4, r);
    check(r == 32'h00, "R1 last bank dir out", NP'(r), '0);
    do_read(bbase(NB - 1), r);
    check(r == 32'h3F, "R1 last bank data", NP'(r), NP'(32'h3F));
    do_write(bbase(NB - 1) + 4, 32'hFF);
    do_read(bbase(NB - 1) + 4, r);
    check(r == 32'h3F, "R1 last bank dir in", NP'(r), NP'(32'h3F));

    // R8 writes to unmapped addresses, hole included
    for (int a = 0; a < 256; a++) begin
      if (exp_read(a) == '0 && a != bbase(NB-1) && a != bbase(0) && a != bbase(0) + 4) begin
        bit hit;
        hit = 1'b0;
        for (int b = 0; b < NB; b++)
          if (a == bbase(b) || a == bbase(b) + 4) hit = 1'b1;
        if (!hit) do_write(a, 32'hFFFF_FFFF);
      end
    end
    check_pins("R8 unmapped writes");
    sweep("R8 R2 sweep after unmapped writes");

    // R9 synchronizer latency on pin 0 (input)
    do_write(bbase(0) + 4, 32'h01);
    do_write(bbase(0), 32'h00);
    pin_in[0] = 1'b0;
    repeat (4) @(negedge clk);
    @(posedge clk); #1;
    pin_in[0] = 1'b1;
    @(negedge clk);
    rd_en = 1'b1; addr = AW'(bbase(0));
    @(negedge clk);
    check(rdata[0] == 1'b0, "R9 first edge old", NP'(rdata[0]), '0);
    @(negedge clk);
    check(rdata[0] == 1'b0, "R9 second edge old", NP'(rdata[0]), '0);
    @(negedge clk);
    check(rdata[0] == 1'b1, "R9 third edge new", NP'(rdata[0]), NP'(1));
    rd_en = 1'b0;
    @(negedge clk);
    check(rdata == '0, "R10 idle rdata", NP'(rdata), '0);

    // R4 output line follows data, ignores pin
    do_write(bbase(0) + 4, 32'h00);
    do_write(bbase(0), 32'h02);
    pin_in[7:0] = 8'hF5;
    repeat (3) @(negedge clk);
    check_pins("R4 output drive");
    do_read(bbase(0), r);
    check(r == 32'h02, "R6 output readback", NP'(r), NP'(32'h02));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule